// File: doc/BRIEF.md
# Accumulator ALU with condition codes

This block is the arithmetic and logic stage of a small accumulator-based microcontroller core. Each cycle in which the issue strobe is high, it takes an operation code, a destination operand (the accumulator, the index register or a memory byte, already fetched by the core) and a source byte. It computes a result and updates a five-flag condition code register that it owns. Result and flags are registered. They appear one clock after the strobe, together with a flag that says whether the core should write the result back.

The block does not decode addressing modes, access memory or evaluate branches; the core handles those. A separate masked write port into the flag register serves the instructions that set or clear the carry and the interrupt mask, and any direct restore of the flags. The flag register holds half carry at bit 4, interrupt mask at bit 3, negative at bit 2, zero at bit 1 and carry at bit 0. The datapath width is a parameter (8 by default). Half carry is always the carry out of the lower half of the operand.

Top module: `acc_alu_cc`

## Requirements
- R1: While `rst_n` is low at a clock edge, `result` becomes 0, `res_valid` and `res_wr` become 0, and `cc` becomes 5'b01000 (only the interrupt mask set).
- R2: Operation codes: 0 ADD, 1 ADC, 2 SUB, 3 SBC, 4 CMP, 5 AND, 6 OR, 7 XOR, 8 BIT, 9 COM, 10 NEG, 11 CLR, 12 INC, 13 DEC, 14 TST, 15 ASL, 16 ASR, 17 LSR, 18 ROL, 19 ROR, 20 MOV. Codes 21 to 31 are undefined. An issued undefined code leaves `result` and `cc` unchanged and gives `res_valid` = 0 and `res_wr` = 0 in the following cycle.
- R3: Every defined operation issued at edge k gives `res_valid` = 1 after edge k. `res_wr` is then 0 for CMP, BIT and TST and 1 for all others. Every defined operation sets N to the result's top bit and Z to (result == 0), and never alters the interrupt mask.
- R4: ADD computes d+s and ADC computes d+s+C, modulo 2^DATA_W. C takes the carry out of the top bit. H takes the carry out of bit DATA_W/2-1 (bit 3 by default).
- R5: SUB computes d−s, SBC computes d−s−C and CMP computes d−s. C is set exactly when s plus the borrow-in exceeds d as unsigned numbers. H is unchanged.
- R6: AND, OR, XOR, BIT (d&s) and MOV (s) change only N and Z among the flags. C and H keep their values.
- R7: COM gives ~d and sets C to 1. NEG gives 0−d and sets C exactly when d is nonzero. H is unchanged by both.
- R8: CLR gives 0, with N = 0, Z = 1 and C = 0. H is unchanged.
- R9: INC (d+1), DEC (d−1) and TST (d) leave C and H unchanged.
- R10: ASL shifts d left with 0 into bit 0 and the old top bit into C. ASR shifts d right, keeping the top bit, with the old bit 0 into C.
- R11: LSR shifts d right with 0 into the top bit and the old bit 0 into C, so N is always 0 afterwards.
- R12: ROL and ROR rotate d through C as a (DATA_W+1)-bit ring. ROL puts the old C into bit 0 and the old top bit into C. ROR puts the old C into the top bit and the old bit 0 into C.
- R13: With neither `op_valid` nor `cc_we` high, `cc` and `result` hold and `res_valid` and `res_wr` are 0 after the edge.
- R14: With `cc_we` high, each flag whose `cc_wmask` bit is 1 takes the matching `cc_wdata` bit after the edge. This takes priority over the flags of an operation issued in the same cycle. Unmasked flags follow R3 to R13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Issue strobe, one cycle per operation |
| op_code | input | 5 | Operation code (R2) |
| dst_in | input | DATA_W | Destination operand d (A, X or memory byte) |
| src_in | input | DATA_W | Source operand s |
| cc_we | input | 1 | Flag write port enable |
| cc_wmask | input | 5 | Flags selected for the write port |
| cc_wdata | input | 5 | Values for the selected flags |
| result | output | DATA_W | Registered result |
| res_valid | output | 1 | A defined operation completed at the last edge |
| res_wr | output | 1 | Result should be written back |
| cc | output | 5 | Flags {H, I, N, Z, C} |

## Verification
The bench builds the block with DATA_W = 4. This makes every pair of destination and source values reachable for each of the 32 operation codes. Each pair is run twice with different preset flags, so both carry-in values and both prior H values reach every operation. At this width the half carry comes out of bit 1, so the half-carry rule is exercised as fully as the carry rule. Directed steps cover reset, idle holding, and the write port overriding an operation's flags in the same cycle.

// File: rtl/acc_alu_pkg.sv
// Shared definitions for the accumulator ALU: operation codes and flag
// bit positions. Assumes a 5-bit operation code and a 5-bit flag register.
package acc_alu_pkg;

    typedef enum logic [4:0] {
        OP_ADD = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,  OP_SBC = 5'd3,
        OP_CMP = 5'd4,  OP_AND = 5'd5,  OP_OR  = 5'd6,  OP_XOR = 5'd7,
        OP_BIT = 5'd8,  OP_COM = 5'd9,  OP_NEG = 5'd10, OP_CLR = 5'd11,
        OP_INC = 5'd12, OP_DEC = 5'd13, OP_TST = 5'd14, OP_ASL = 5'd15,
        OP_ASR = 5'd16, OP_LSR = 5'd17, OP_ROL = 5'd18, OP_ROR = 5'd19,
        OP_MOV = 5'd20
    } alu_op_e;

    localparam int CC_W  = 5;
    localparam int FLG_C = 0;
    localparam int FLG_Z = 1;
    localparam int FLG_N = 2;
    localparam int FLG_I = 3;
    localparam int FLG_H = 4;

    localparam logic [CC_W-1:0] CC_RESET = 5'b01000;

endpackage

// File: rtl/alu_addsub.sv
// Adder/subtractor with carry-in. In add mode cout is the carry out and
// half is the carry out of the lower half. In subtract mode cout is the
// borrow (b + cin exceeds a). Assumes HALF < W.
module alu_addsub #(
    parameter int W    = 8,
    parameter int HALF = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         half
);
    logic [W:0]    wide;
    logic [HALF:0] low;

    // Full-width and lower-half sums with one extra bit for carry/borrow
    always_comb begin
        if (sub) begin
            wide = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, cin};
            low  = {1'b0, a[HALF-1:0]} - {1'b0, b[HALF-1:0]} - {{HALF{1'b0}}, cin};
        end else begin
            wide = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
            low  = {1'b0, a[HALF-1:0]} + {1'b0, b[HALF-1:0]} + {{HALF{1'b0}}, cin};
        end
    end

    assign sum  = wide[W-1:0];
    assign cout = wide[W];
    assign half = low[HALF];

endmodule

// File: rtl/alu_shift.sv
// Single-bit shifter/rotator. For the shift and rotate operations it
// returns the shifted value and the bit that leaves the operand. For any
// other code it passes d and cin through.
module alu_shift
    import acc_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_op_e      op,
    input  logic [W-1:0] d,
    input  logic         cin,
    output logic [W-1:0] r,
    output logic         cout
);
    // Select the shift or rotate form
    always_comb begin
        case (op)
            OP_ASL:  begin r = {d[W-2:0], 1'b0};   cout = d[W-1]; end
            OP_ASR:  begin r = {d[W-1], d[W-1:1]}; cout = d[0];   end
            OP_LSR:  begin r = {1'b0, d[W-1:1]};   cout = d[0];   end
            OP_ROL:  begin r = {d[W-2:0], cin};    cout = d[W-1]; end
            OP_ROR:  begin r = {cin, d[W-1:1]};    cout = d[0];   end
            default: begin r = d;                  cout = cin;    end
        endcase
    end

endmodule

// File: rtl/alu_logic.sv
// Bitwise and single-operand unit: AND/OR/XOR/BIT, complement, clear,
// increment, decrement, test and move. Does not produce flags.
module alu_logic
    import acc_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_op_e      op,
    input  logic [W-1:0] d,
    input  logic [W-1:0] s,
    output logic [W-1:0] r
);
    // Pick the value the operation produces
    always_comb begin
        case (op)
            OP_AND, OP_BIT: r = d & s;
            OP_OR:          r = d | s;
            OP_XOR:         r = d ^ s;
            OP_COM:         r = ~d;
            OP_CLR:         r = '0;
            OP_INC:         r = d + W'(1);
            OP_DEC:         r = d - W'(1);
            OP_MOV:         r = s;
            default:        r = d;
        endcase
    end

endmodule

// File: rtl/acc_alu_cc.sv
// Accumulator ALU with condition code register. Each strobed operation
// registers its result and flags on the next edge. A masked write port
// into the flags takes priority over the operation's flags. Assumes
// DATA_W is even and at least 4, and that op_valid is a one-cycle strobe.
module acc_alu_cc
    import acc_alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [4:0]        op_code,
    input  logic [DATA_W-1:0] dst_in,
    input  logic [DATA_W-1:0] src_in,
    input  logic              cc_we,
    input  logic [CC_W-1:0]   cc_wmask,
    input  logic [CC_W-1:0]   cc_wdata,
    output logic [DATA_W-1:0] result,
    output logic              res_valid,
    output logic              res_wr,
    output logic [CC_W-1:0]   cc
);
    localparam int HALF = DATA_W / 2;

    alu_op_e           op;
    logic [CC_W-1:0]   cc_q;
    logic [DATA_W-1:0] res_q;

    logic [DATA_W-1:0] as_a, as_b, as_sum;
    logic              as_cin, as_sub, as_cout, as_half;
    logic [DATA_W-1:0] sh_r, lg_r;
    logic              sh_c;

    logic [DATA_W-1:0] nres;
    logic [CC_W-1:0]   nflg, cc_base, cc_next;
    logic              legal, wr;

    assign op = alu_op_e'(op_code);

    // Operand steering for the adder: NEG is 0 - d, the rest are d op s
    always_comb begin
        as_a   = (op == OP_NEG) ? '0 : dst_in;
        as_b   = (op == OP_NEG) ? dst_in : src_in;
        as_sub = !(op == OP_ADD || op == OP_ADC);
        as_cin = (op == OP_ADC || op == OP_SBC) && cc_q[FLG_C];
    end

    alu_addsub #(.W(DATA_W), .HALF(HALF)) u_addsub (
        .a(as_a), .b(as_b), .cin(as_cin), .sub(as_sub),
        .sum(as_sum), .cout(as_cout), .half(as_half)
    );

    alu_shift #(.W(DATA_W)) u_shift (
        .op(op), .d(dst_in), .cin(cc_q[FLG_C]), .r(sh_r), .cout(sh_c)
    );

    alu_logic #(.W(DATA_W)) u_logic (
        .op(op), .d(dst_in), .s(src_in), .r(lg_r)
    );

    // Result, write-back and flag rules per operation
    always_comb begin
        nflg  = cc_q;
        nres  = res_q;
        legal = 1'b1;
        wr    = 1'b1;
        case (op)
            OP_ADD, OP_ADC: begin
                nres = as_sum; nflg[FLG_C] = as_cout; nflg[FLG_H] = as_half;
            end
            OP_SUB, OP_SBC, OP_NEG: begin
                nres = as_sum; nflg[FLG_C] = as_cout;
            end
            OP_CMP: begin
                nres = as_sum; nflg[FLG_C] = as_cout; wr = 1'b0;
            end
            OP_AND, OP_OR, OP_XOR, OP_INC, OP_DEC, OP_MOV: nres = lg_r;
            OP_BIT, OP_TST: begin
                nres = lg_r; wr = 1'b0;
            end
            OP_COM: begin
                nres = lg_r; nflg[FLG_C] = 1'b1;
            end
            OP_CLR: begin
                nres = lg_r; nflg[FLG_C] = 1'b0;
            end
            OP_ASL, OP_ASR, OP_LSR, OP_ROL, OP_ROR: begin
                nres = sh_r; nflg[FLG_C] = sh_c;
            end
            default: begin
                legal = 1'b0; wr = 1'b0;
            end
        endcase
        if (legal) begin
            nflg[FLG_N] = nres[DATA_W-1];
            nflg[FLG_Z] = (nres == '0);
        end
    end

    // Merge operation flags with the masked write port (port wins)
    always_comb begin
        cc_base = (op_valid && legal) ? nflg : cc_q;
        cc_next = cc_we ? ((cc_base & ~cc_wmask) | (cc_wdata & cc_wmask)) : cc_base;
    end

    // Flag register
    always_ff @(posedge clk) begin
        if (!rst_n) cc_q <= CC_RESET;
        else        cc_q <= cc_next;
    end

    // Result register and completion strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q     <= '0;
            res_valid <= 1'b0;
            res_wr    <= 1'b0;
        end else begin
            res_valid <= op_valid && legal;
            res_wr    <= op_valid && legal && wr;
            if (op_valid && legal) res_q <= nres;
        end
    end

    assign result = res_q;
    assign cc     = cc_q;

endmodule

// File: rtl/acc_alu_cc_chk.sv
// Property checker for acc_alu_cc. It observes ports only and is bound
// to every instance of the top module.
module acc_alu_cc_chk
    import acc_alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic [4:0]        op_code,
    input logic [DATA_W-1:0] dst_in,
    input logic              cc_we,
    input logic [CC_W-1:0]   cc_wmask,
    input logic [CC_W-1:0]   cc_wdata,
    input logic [DATA_W-1:0] result,
    input logic              res_valid,
    input logic              res_wr,
    input logic [CC_W-1:0]   cc
);
    // R13
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid && !cc_we) |=> ($stable(cc) && $stable(result) && !res_valid && !res_wr));

    // R2
    undef_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code > 5'd20 && !cc_we) |=> ($stable(cc) && $stable(result) && !res_valid));

    // R3
    compare_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_code == OP_CMP || op_code == OP_BIT || op_code == OP_TST)) |=> (res_valid && !res_wr));

    // R7
    com_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_COM && !cc_we) |=> cc[FLG_C]);

    // R8
    clr_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_CLR && !cc_we) |=> (result == '0 && cc[FLG_Z] && !cc[FLG_N] && !cc[FLG_C]));

    // R9
    incdec_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_code == OP_INC || op_code == OP_DEC || op_code == OP_TST) && !cc_we)
        |=> ($stable(cc[FLG_C]) && $stable(cc[FLG_H])));

    // R11
    lsr_negative_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_LSR && !cc_we) |=> (!cc[FLG_N] && !result[DATA_W-1]));

    // R12
    rol_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_ROL && !cc_we)
        |=> (result[0] == $past(cc[FLG_C]) && cc[FLG_C] == $past(dst_in[DATA_W-1])));

    // R14
    cc_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cc_we |=> (((cc ^ $past(cc_wdata)) & $past(cc_wmask)) == '0));

endmodule

bind acc_alu_cc acc_alu_cc_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .dst_in(dst_in), .cc_we(cc_we), .cc_wmask(cc_wmask), .cc_wdata(cc_wdata),
    .result(result), .res_valid(res_valid), .res_wr(res_wr), .cc(cc)
);

// File: tb/sim_acc_alu_cc.sv
`timescale 1ns/100ps
// Bench: 4-bit build, every operation code over every operand pair with
// two flag presets each; expected values from an arithmetic model.
module sim_acc_alu_cc;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         op_valid = 1'b0;
    logic [4:0]   op_code = '0;
    logic [W-1:0] dst_in = '0, src_in = '0;
    logic         cc_we = 1'b0;
    logic [4:0]   cc_wmask = '0, cc_wdata = '0;
    logic [W-1:0] result;
    logic         res_valid, res_wr;
    logic [4:0]   cc;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    int         exp_res = 0;
    logic [4:0] exp_cc  = 5'b01000;
    logic       exp_valid = 1'b0, exp_wr = 1'b0;

    always #2.5 clk = ~clk;

    acc_alu_cc #(.DATA_W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .dst_in(dst_in), .src_in(src_in), .cc_we(cc_we), .cc_wmask(cc_wmask),
        .cc_wdata(cc_wdata), .result(result), .res_valid(res_valid),
        .res_wr(res_wr), .cc(cc)
    );

    function automatic string tag_of(input int op);
        case (op)
            0, 1:              return "R4";
            2, 3, 4:           return "R5";
            5, 6, 7, 8, 20:    return "R6";
            9, 10:             return "R7";
            11:                return "R8";
            12, 13, 14:        return "R9";
            15, 16:            return "R10";
            17:                return "R11";
            18, 19:            return "R12";
            default:           return "R2";
        endcase
    endfunction

    // Arithmetic model of one issued operation
    task automatic model_op(input int op, input int d, input int s);
        int m  = (1 << W) - 1;
        int hm = (1 << (W / 2)) - 1;
        int c  = int'(exp_cc[0]);
        int r  = 0;
        int k  = 0;
        logic [4:0] f = exp_cc;
        logic legal = 1'b1;
        logic wr = 1'b1;
        case (op)
            0, 1:  begin k = (op == 1) ? c : 0; r = d + s + k;
                         f[4] = ((d & hm) + (s & hm) + k) > hm; f[0] = r > m; end
            2, 3, 4: begin k = (op == 3) ? c : 0; f[0] = (s + k) > d; r = d - s - k;
                         if (op == 4) wr = 1'b0; end
            5:  r = d & s;
            6:  r = d | s;
            7:  r = d ^ s;
            8:  begin r = d & s; wr = 1'b0; end
            9:  begin r = m - d; f[0] = 1'b1; end
            10: begin r = -d; f[0] = (d != 0); end
            11: begin r = 0; f[0] = 1'b0; end
            12: r = d + 1;
            13: r = d - 1;
            14: begin r = d; wr = 1'b0; end
            15: begin f[0] = d[W-1]; r = d * 2; end
            16: begin f[0] = d[0]; r = (d / 2) + (d & (1 << (W - 1))); end
            17: begin f[0] = d[0]; r = d / 2; end
            18: begin f[0] = d[W-1]; r = d * 2 + c; end
            19: begin f[0] = d[0]; r = d / 2 + c * (1 << (W - 1)); end
            20: r = s;
            default: legal = 1'b0;
        endcase
        if (legal) begin
            r = r & m;
            f[2] = r[W-1];
            f[1] = (r == 0);
            exp_res = r; exp_cc = f; exp_valid = 1'b1; exp_wr = wr;
        end else begin
            exp_valid = 1'b0; exp_wr = 1'b0;
        end
    endtask

    task automatic compare(input string tag);
        checks++;
        if (int'(result) != exp_res || cc != exp_cc || res_valid != exp_valid || res_wr != exp_wr) begin
            fails++;
            $display("FAIL %s op=%0d d=%0d s=%0d: got res=%0d cc=%b v=%b w=%b, expected res=%0d cc=%b v=%b w=%b",
                     tag, op_code, dst_in, src_in, result, cc, res_valid, res_wr,
                     exp_res, exp_cc, exp_valid, exp_wr);
        end
    endtask

    // One clock: apply inputs, clock, then update the model
    task automatic step(input logic v, input int op, input int d, input int s,
                        input logic we, input logic [4:0] mk, input logic [4:0] dt);
        op_valid = v; op_code = 5'(op); dst_in = W'(d); src_in = W'(s);
        cc_we = we; cc_wmask = mk; cc_wdata = dt;
        @(posedge clk); #1;
        if (v) model_op(op, d, s);
        else begin exp_valid = 1'b0; exp_wr = 1'b0; end
        if (we) exp_cc = (exp_cc & ~mk) | (dt & mk);
        op_valid = 1'b0; cc_we = 1'b0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        exp_res = 0; exp_cc = 5'b01000; exp_valid = 0; exp_wr = 0;
        compare("R1");
        rst_n = 1'b1;

        // R3..R12 and R2: full sweep with two flag presets
        for (int op = 0; op < 32; op++) begin
            for (int d = 0; d < (1 << W); d++) begin
                for (int s = 0; s < (1 << W); s++) begin
                    for (int v = 0; v < 2; v++) begin
                        logic [4:0] pre;
                        pre = {logic'(v) ^ logic'(d & 1), logic'(s & 1),
                               logic'((d >> 1) & 1) ^ logic'(v), logic'((s >> 1) & 1), logic'(v)};
                        step(1'b0, 0, d, s, 1'b1, 5'b11111, pre);
                        step(1'b1, op, d, s, 1'b0, 5'b0, 5'b0);
                        compare(tag_of(op));
                    end
                end
            end
        end

        // R13: idle cycles hold everything
        step(1'b1, 0, 9, 9, 1'b0, 5'b0, 5'b0);
        compare("R4");
        step(1'b0, 0, 3, 3, 1'b0, 5'b0, 5'b0);
        compare("R13");
        step(1'b0, 7, 1, 2, 1'b0, 5'b0, 5'b0);
        compare("R13");

        // R14: write port overrides op flags (ADD 15+1 gives C=1, port forces C=0, clears I)
        step(1'b0, 0, 0, 0, 1'b1, 5'b11111, 5'b01000);
        compare("R14");
        step(1'b1, 0, 15, 1, 1'b1, 5'b01001, 5'b00000);
        compare("R14");
        step(1'b0, 0, 0, 0, 1'b1, 5'b01000, 5'b01000);
        compare("R14");
        // R3: interrupt mask kept through operations
        step(1'b1, 11, 5, 0, 1'b0, 5'b0, 5'b0);
        compare("R3");

        done = 1'b1;
        summary();
        $finish;
    end

    // Watchdog: a hung run is counted as a failed check
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: got timeout, expected completion");
            summary();
            $finish;
        end
    end

endmodule